// File: doc/BRIEF.md
# Scatter-Gather Descriptor Fetch Engine

The engine walks a chain of transfer descriptors held in memory. Each descriptor is read word by word over a memory read port. It becomes one command word that goes to the read engine's command FIFO and an identical command word that goes to the write engine's command FIFO. The engine then follows the descriptor's link word to the next descriptor. The walk stops at the first descriptor whose hardware-ownership bit is clear.

When the data engines finish a command, each returns a status token holding the actual byte count and eight error bits. The engine keeps an ordered list of the descriptors whose commands were issued but whose status is still open. It writes each token back into its descriptor over a separate memory write port, strictly in list order. Because fetching and writeback run concurrently, later descriptors can be fetched while earlier ones still wait for status.

Software places the list in memory, pulses `start` with the address of the first descriptor, and watches `busy`. All addresses are word addresses, and memory words are 32 bits wide.

Top module: `sgd_fetch_engine`

## Requirements
- R1: A one-cycle `start` while `busy` is low begins a walk at `start_addr`. `busy` reads high from the next cycle and falls only after the last status write of the walk is acknowledged.
- R2: A descriptor occupies word offsets from its base address. +0 holds the source address, +1 the destination address, and +2 the control word. The control word holds the byte count in [15:0], increment-read in bit 24, increment-write in bit 25, packet framing (generate start and end markers) in bit 26, and hardware-owned in bit 31. +3 holds the next-descriptor address. The engine reads +2, +0, +1 and +3 in that order, and holds each read request and address until it is acknowledged.
- R3: Every owned descriptor yields exactly one command to each engine, with the same word for both. The command is {framing, inc_write, inc_read, count[15:0], dst, src}, with src in the least significant AW bits.
- R4: A descriptor whose bit 31 is clear ends the walk. Only its control word is read, and it produces no command and no status write.
- R5: A command is pushed only in a cycle where both command FIFOs report not-full. While either FIFO reports full, neither push is asserted and the walk waits.
- R6: The read-engine token is written to offset +4 and the write-engine token to offset +5. Each is written as {1'b1 at bit 31, 7'b0, err[7:0] at [23:16], count[15:0]}, where the token carries err in [23:16] and count in [15:0]. A write request holds its address and data until acknowledged.
- R7: Status writes follow list order. Both writes of one descriptor complete before any write of the next. The read token is taken before the write token.
- R8: `start` is ignored while `busy` is high, including the interval after the walk has ended but status is still open.
- R9: At most PEND_DEPTH descriptors may have issued commands with status still open. Fetching stalls before the next push until a slot frees.
- R10: During and after reset, `busy`, both pushes, both memory requests and both token-ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| start_addr | input | AW | Address of the first descriptor |
| busy | output | 1 | Walk or status writeback in progress |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read word address |
| mem_rd_data | input | 32 | Read data, valid with acknowledge |
| mem_rd_ack | input | 1 | Read acknowledge |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | AW | Memory write word address |
| mem_wr_data | output | 32 | Memory write data |
| mem_wr_ack | input | 1 | Write acknowledge |
| rd_cmd_push | output | 1 | Push into read engine command FIFO |
| rd_cmd_data | output | 2*AW+19 | Read engine command word |
| rd_cmd_full | input | 1 | Read engine command FIFO full |
| wr_cmd_push | output | 1 | Push into write engine command FIFO |
| wr_cmd_data | output | 2*AW+19 | Write engine command word |
| wr_cmd_full | input | 1 | Write engine command FIFO full |
| rd_sts_valid | input | 1 | Read engine status token valid |
| rd_sts_data | input | 24 | Read engine token: err[23:16], count[15:0] |
| rd_sts_ready | output | 1 | Read engine token accepted |
| wr_sts_valid | input | 1 | Write engine status token valid |
| wr_sts_data | input | 24 | Write engine token: err[23:16], count[15:0] |
| wr_sts_ready | output | 1 | Write engine token accepted |

## Verification
The hardest state to reach is the one where the pending list is full. In that state the walker has already fetched a further descriptor and is parked before its push. This occurs only when the engines withhold status long enough. The bench builds a chain of six descriptors and returns no tokens until the command counts settle. It then releases the tokens one descriptor at a time and checks the order of the status-write addresses. A second hard case is a `start` that arrives after the walk has ended but while writeback is still open. The bench produces it by holding back tokens after the terminating descriptor has been read, then checks that no extra memory read appears.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 16;
  localparam int ERR_W  = 8;
  localparam int TOK_W  = LEN_W + ERR_W;

  // Word offsets inside one descriptor
  localparam logic [2:0] OFS_SRC  = 3'd0;
  localparam logic [2:0] OFS_DST  = 3'd1;
  localparam logic [2:0] OFS_CTL  = 3'd2;
  localparam logic [2:0] OFS_NXT  = 3'd3;
  localparam logic [2:0] OFS_RSTS = 3'd4;
  localparam logic [2:0] OFS_WSTS = 3'd5;

  // Control word bit positions
  localparam int BIT_INC_RD = 24;
  localparam int BIT_INC_WR = 25;
  localparam int BIT_FRAME  = 26;
  localparam int BIT_OWN    = 31;

  typedef enum logic [2:0] {
    F_IDLE, F_CTL, F_SRC, F_DST, F_NXT, F_PUSH
  } fetch_st_e;

  typedef enum logic [2:0] {
    W_IDLE, W_RTOK, W_RPUT, W_WTOK, W_WPUT
  } wb_st_e;

  function automatic logic [WORD_W-1:0] sts_word(input logic [TOK_W-1:0] tok);
    return {1'b1, 7'b0, tok[TOK_W-1:LEN_W], tok[LEN_W-1:0]};
  endfunction
endpackage

// File: rtl/sgd_pend_fifo.sv
module sgd_pend_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [PW:0]   cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && (wp_q == PW'(g))) slot_q[g] <= push_data;
      end
    end
  endgenerate

  always_comb begin
    wp_d  = push ? bump(wp_q) : wp_q;
    rp_d  = pop  ? bump(rp_q) : rp_q;
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  assign head  = slot_q[rp_q];
  assign full  = (cnt_q == (PW+1)'(DEPTH));
  assign empty = (cnt_q == '0);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sgd_walker.sv
module sgd_walker import sgd_pkg::*; #(
  parameter int AW     = 16,
  localparam int CMD_W = 2*AW + LEN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [AW-1:0]     go_addr,
  output logic              walking,
  output logic              mem_rd_req,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  input  logic              mem_rd_ack,
  output logic              cmd_push,
  output logic [CMD_W-1:0]  cmd_data,
  input  logic              rd_cmd_full,
  input  logic              wr_cmd_full,
  input  logic              pend_full,
  output logic [AW-1:0]     pend_addr
);
  fetch_st_e        st_q, st_d;
  logic [AW-1:0]    cur_q, cur_d;
  logic             cur_en;
  logic [AW-1:0]    src_q, dst_q, nxt_q;
  logic [LEN_W-1:0] len_q;
  logic             inc_rd_q, inc_wr_q, frame_q;
  logic             cap_ctl, cap_src, cap_dst, cap_nxt, fire;
  logic [2:0]       ofs;

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    cur_en  = 1'b0;
    cap_ctl = 1'b0;
    cap_src = 1'b0;
    cap_dst = 1'b0;
    cap_nxt = 1'b0;
    fire    = 1'b0;
    unique case (st_q)
      F_IDLE: if (go) begin
        st_d   = F_CTL;
        cur_d  = go_addr;
        cur_en = 1'b1;
      end
      F_CTL: if (mem_rd_ack) begin
        if (mem_rd_data[BIT_OWN]) begin
          cap_ctl = 1'b1;
          st_d    = F_SRC;
        end else begin
          st_d = F_IDLE;
        end
      end
      F_SRC: if (mem_rd_ack) begin
        cap_src = 1'b1;
        st_d    = F_DST;
      end
      F_DST: if (mem_rd_ack) begin
        cap_dst = 1'b1;
        st_d    = F_NXT;
      end
      F_NXT: if (mem_rd_ack) begin
        cap_nxt = 1'b1;
        st_d    = F_PUSH;
      end
      F_PUSH: if (!rd_cmd_full && !wr_cmd_full && !pend_full) begin
        fire   = 1'b1;
        cur_d  = nxt_q;
        cur_en = 1'b1;
        st_d   = F_CTL;
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_q)
      F_SRC:   ofs = OFS_SRC;
      F_DST:   ofs = OFS_DST;
      F_NXT:   ofs = OFS_NXT;
      default: ofs = OFS_CTL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= F_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (cur_en)  cur_q <= cur_d;
    if (cap_src) src_q <= mem_rd_data[AW-1:0];
    if (cap_dst) dst_q <= mem_rd_data[AW-1:0];
    if (cap_nxt) nxt_q <= mem_rd_data[AW-1:0];
    if (cap_ctl) begin
      len_q    <= mem_rd_data[LEN_W-1:0];
      inc_rd_q <= mem_rd_data[BIT_INC_RD];
      inc_wr_q <= mem_rd_data[BIT_INC_WR];
      frame_q  <= mem_rd_data[BIT_FRAME];
    end
  end

  assign walking     = (st_q != F_IDLE);
  assign mem_rd_req  = (st_q == F_CTL) || (st_q == F_SRC) ||
                       (st_q == F_DST) || (st_q == F_NXT);
  assign mem_rd_addr = cur_q + {{(AW-3){1'b0}}, ofs};
  assign cmd_push    = fire;
  assign cmd_data    = {frame_q, inc_wr_q, inc_rd_q, len_q, dst_q, src_q};
  assign pend_addr   = cur_q;

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr));
  p_push_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push |-> !rd_cmd_full && !wr_cmd_full);
  p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == F_CTL) && mem_rd_ack && !mem_rd_data[BIT_OWN] |=> !cmd_push && !mem_rd_req);
endmodule

// File: rtl/sgd_writeback.sv
module sgd_writeback import sgd_pkg::*; #(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_empty,
  input  logic [AW-1:0]     pend_head,
  output logic              pend_pop,
  input  logic              rd_sts_valid,
  input  logic [TOK_W-1:0]  rd_sts_data,
  output logic              rd_sts_ready,
  input  logic              wr_sts_valid,
  input  logic [TOK_W-1:0]  wr_sts_data,
  output logic              wr_sts_ready,
  output logic              mem_wr_req,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              active
);
  wb_st_e           st_q, st_d;
  logic [TOK_W-1:0] tok_q, tok_d;
  logic             tok_en;

  always_comb begin
    st_d     = st_q;
    tok_d    = tok_q;
    tok_en   = 1'b0;
    pend_pop = 1'b0;
    unique case (st_q)
      W_IDLE: if (!pend_empty) st_d = W_RTOK;
      W_RTOK: if (rd_sts_valid) begin
        tok_d  = rd_sts_data;
        tok_en = 1'b1;
        st_d   = W_RPUT;
      end
      W_RPUT: if (mem_wr_ack) st_d = W_WTOK;
      W_WTOK: if (wr_sts_valid) begin
        tok_d  = wr_sts_data;
        tok_en = 1'b1;
        st_d   = W_WPUT;
      end
      W_WPUT: if (mem_wr_ack) begin
        pend_pop = 1'b1;
        st_d     = W_IDLE;
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (tok_en) tok_q <= tok_d;
  end

  assign rd_sts_ready = (st_q == W_RTOK);
  assign wr_sts_ready = (st_q == W_WTOK);
  assign mem_wr_req   = (st_q == W_RPUT) || (st_q == W_WPUT);
  assign mem_wr_addr  = pend_head +
                        {{(AW-3){1'b0}}, (st_q == W_WPUT) ? OFS_WSTS : OFS_RSTS};
  assign mem_wr_data  = sts_word(tok_q);
  assign active       = (st_q != W_IDLE);

  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));
  p_one_at_a_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_sts_ready, wr_sts_ready, mem_wr_req}));
  p_write_has_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !pend_empty);
endmodule

// File: rtl/sgd_fetch_engine.sv
module sgd_fetch_engine import sgd_pkg::*; #(
  parameter int AW         = 16,
  parameter int PEND_DEPTH = 4,
  localparam int CMD_W     = 2*AW + LEN_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  output logic              busy,
  output logic              mem_rd_req,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [WORD_W-1:0] mem_rd_data,
  input  logic              mem_rd_ack,
  output logic              mem_wr_req,
  output logic [AW-1:0]     mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              rd_cmd_push,
  output logic [CMD_W-1:0]  rd_cmd_data,
  input  logic              rd_cmd_full,
  output logic              wr_cmd_push,
  output logic [CMD_W-1:0]  wr_cmd_data,
  input  logic              wr_cmd_full,
  input  logic              rd_sts_valid,
  input  logic [TOK_W-1:0]  rd_sts_data,
  output logic              rd_sts_ready,
  input  logic              wr_sts_valid,
  input  logic [TOK_W-1:0]  wr_sts_data,
  output logic              wr_sts_ready
);
  logic             go, walking, cmd_push, wb_active;
  logic [CMD_W-1:0] cmd_data;
  logic             pend_full, pend_empty, pend_pop;
  logic [AW-1:0]    pend_addr, pend_head;

  assign busy = walking || !pend_empty || wb_active;
  assign go   = start && !busy;

  sgd_walker #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .go(go), .go_addr(start_addr), .walking(walking),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_ack(mem_rd_ack), .cmd_push(cmd_push), .cmd_data(cmd_data),
    .rd_cmd_full(rd_cmd_full), .wr_cmd_full(wr_cmd_full),
    .pend_full(pend_full), .pend_addr(pend_addr)
  );

  sgd_pend_fifo #(.W(AW), .DEPTH(PEND_DEPTH)) u_pend (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .push_data(pend_addr),
    .pop(pend_pop), .head(pend_head), .full(pend_full), .empty(pend_empty)
  );

  sgd_writeback #(.AW(AW)) u_wb (
    .clk(clk), .rst_n(rst_n), .pend_empty(pend_empty), .pend_head(pend_head),
    .pend_pop(pend_pop), .rd_sts_valid(rd_sts_valid), .rd_sts_data(rd_sts_data),
    .rd_sts_ready(rd_sts_ready), .wr_sts_valid(wr_sts_valid),
    .wr_sts_data(wr_sts_data), .wr_sts_ready(wr_sts_ready),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .active(wb_active)
  );

  assign rd_cmd_push = cmd_push;
  assign wr_cmd_push = cmd_push;
  assign rd_cmd_data = cmd_data;
  assign wr_cmd_data = cmd_data;

  p_activity_in_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req || mem_wr_req || rd_cmd_push) |-> busy);
  p_start_begins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && mem_rd_req);
endmodule

// File: tb/sim_sgd_fetch_engine.sv
module sim_sgd_fetch_engine;
  localparam int AW = 16;
  localparam int CW = 2*AW + 19;

  typedef struct packed {
    logic [15:0] src;
    logic [15:0] dst;
    logic [15:0] len;
    logic [2:0]  flg;   // bit0 inc_read, bit1 inc_write, bit2 framing
    logic [23:0] rtok;
    logic [23:0] wtok;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h1000, 16'h2000, 16'd64,    3'b011, 24'h000040, 24'h000040},
    '{16'h0004, 16'hFFF0, 16'd1,     3'b100, 24'h000001, 24'h000001},
    '{16'hABCD, 16'h1234, 16'hFFFF,  3'b111, 24'h00FFFF, 24'h05FFF0},
    '{16'h0000, 16'h0000, 16'd0,     3'b000, 24'h000000, 24'h000000},
    '{16'h8001, 16'h7FFE, 16'd300,   3'b001, 24'hFF012C, 24'h00012C},
    '{16'h5555, 16'hAAAA, 16'd17,    3'b010, 24'h000011, 24'h800010}
  };

  logic clk, rst_n, start, busy;
  logic [AW-1:0] start_addr, mem_rd_addr, mem_wr_addr;
  logic mem_rd_req, mem_rd_ack, mem_wr_req, mem_wr_ack;
  logic [31:0] mem_rd_data, mem_wr_data;
  logic rd_cmd_push, rd_cmd_full, wr_cmd_push, wr_cmd_full;
  logic [CW-1:0] rd_cmd_data, wr_cmd_data;
  logic rd_sts_valid, rd_sts_ready, wr_sts_valid, wr_sts_ready;
  logic [23:0] rd_sts_data, wr_sts_data;

  sgd_fetch_engine #(.AW(AW), .PEND_DEPTH(4)) u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  logic [31:0] mem [256];
  logic [15:0] rlog [64];
  logic [15:0] wblog [64];
  logic [CW-1:0] rcmd [16];
  logic [CW-1:0] wcmd [16];
  int r_n = 0, wb_n = 0, rc_n = 0, wc_n = 0;
  logic slow = 1'b0;
  int cyc = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] exp_cmd(input vec_t v);
    return {v.flg[2], v.flg[1], v.flg[0], v.len, v.dst, v.src};
  endfunction

  function automatic logic [31:0] ctl_word(input vec_t v, input logic own);
    return {own, 4'b0, v.flg, 8'b0, v.len};
  endfunction

  // memory model: acknowledges at the negative edge, one word per cycle
  initial begin
    mem_rd_ack = 1'b0; mem_wr_ack = 1'b0; mem_rd_data = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rd_ack  = mem_rd_req && (!slow || cyc[0]);
      mem_rd_data = mem[mem_rd_addr[7:0]];
      if (mem_rd_ack) begin
        if (r_n < 64) rlog[r_n] = mem_rd_addr;
        r_n++;
      end
      mem_wr_ack = mem_wr_req && (!slow || !cyc[0]);
      if (mem_wr_ack) begin
        mem[mem_wr_addr[7:0]] = mem_wr_data;
        if (wb_n < 64) wblog[wb_n] = mem_wr_addr;
        wb_n++;
      end
    end
  end

  // command FIFO capture
  initial forever begin
    @(negedge clk);
    if (rd_cmd_push && !rd_cmd_full) begin
      if (rc_n < 16) rcmd[rc_n] = rd_cmd_data;
      rc_n++;
    end
    if (wr_cmd_push && !wr_cmd_full) begin
      if (wc_n < 16) wcmd[wc_n] = wr_cmd_data;
      wc_n++;
    end
  end

  task automatic clear_logs();
    r_n = 0; wb_n = 0; rc_n = 0; wc_n = 0;
  endtask

  task automatic put_desc(input int base, input vec_t v, input int nxt);
    mem[base]   = {16'h0, v.src};
    mem[base+1] = {16'h0, v.dst};
    mem[base+2] = ctl_word(v, 1'b1);
    mem[base+3] = nxt;
    mem[base+4] = '0;
    mem[base+5] = '0;
  endtask

  task automatic kick(input int addr);
    @(posedge clk); #1; start = 1'b1; start_addr = AW'(addr);
    @(posedge clk); #1; start = 1'b0;
  endtask

  task automatic send_rd(input logic [23:0] t);
    @(posedge clk); #1; rd_sts_valid = 1'b1; rd_sts_data = t;
    @(negedge clk);
    while (!rd_sts_ready) @(negedge clk);
    @(posedge clk); #1; rd_sts_valid = 1'b0;
  endtask

  task automatic send_wr(input logic [23:0] t);
    @(posedge clk); #1; wr_sts_valid = 1'b1; wr_sts_data = t;
    @(negedge clk);
    while (!wr_sts_ready) @(negedge clk);
    @(posedge clk); #1; wr_sts_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0;
    rd_cmd_full = 1'b0; wr_cmd_full = 1'b0;
    rd_sts_valid = 1'b0; wr_sts_valid = 1'b0; rd_sts_data = '0; wr_sts_data = '0;
    for (int a = 0; a < 256; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 push", {rd_cmd_push, wr_cmd_push}, 0);
    chk("R10 mem req", {mem_rd_req, mem_wr_req}, 0);
    chk("R10 ready", {rd_sts_ready, wr_sts_ready}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after release", {busy, mem_rd_req, rd_cmd_push}, 0);

    // vector table: one owned descriptor then a terminator
    for (int i = 0; i < 6; i++) begin
      slow = i[0];
      clear_logs();
      put_desc(8, VECS[i], 64);
      mem[66] = '0;
      kick(8);
      @(negedge clk);
      chk($sformatf("R1 busy after start v%0d", i), busy, 1);
      send_rd(VECS[i].rtok);
      send_wr(VECS[i].wtok);
      wait_idle();
      chk($sformatf("R1 idle at end v%0d", i), busy, 0);
      chk($sformatf("R3 rd cmd count v%0d", i), rc_n, 1);
      chk($sformatf("R3 wr cmd count v%0d", i), wc_n, 1);
      chk($sformatf("R3 rd cmd v%0d", i), rcmd[0], exp_cmd(VECS[i]));
      chk($sformatf("R3 wr cmd v%0d", i), wcmd[0], exp_cmd(VECS[i]));
      chk($sformatf("R6 rd status word v%0d", i), mem[12], 32'h8000_0000 | VECS[i].rtok);
      chk($sformatf("R6 wr status word v%0d", i), mem[13], 32'h8000_0000 | VECS[i].wtok);
      chk($sformatf("R2 read order v%0d", i),
          {rlog[0], rlog[1], rlog[2], rlog[3], rlog[4]},
          {16'd10, 16'd8, 16'd9, 16'd11, 16'd66});
      chk($sformatf("R4 read count v%0d", i), r_n, 5);
    end
    slow = 1'b0;

    // R4: list whose first descriptor is not owned
    clear_logs();
    mem[40] = 32'h1111; mem[41] = 32'h2222; mem[42] = 32'h0000_0010; mem[43] = 32'd8;
    mem[44] = '0; mem[45] = '0;
    kick(40);
    wait_idle();
    chk("R4 only control read", r_n, 1);
    chk("R4 control address", rlog[0], 16'd42);
    chk("R4 no command", rc_n + wc_n, 0);
    chk("R4 no status write", wb_n, 0);

    // R5 stall on full, R8 start while busy after walk ended
    clear_logs();
    put_desc(8, VECS[2], 64);
    mem[66] = '0;
    @(posedge clk); #1; rd_cmd_full = 1'b1;
    kick(8);
    repeat (20) @(negedge clk);
    chk("R5 no rd push while full", rc_n, 0);
    chk("R5 no wr push while other full", wc_n, 0);
    chk("R5 busy while stalled", busy, 1);
    @(posedge clk); #1; rd_cmd_full = 1'b0; wr_cmd_full = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 still held by wr full", rc_n + wc_n, 0);
    @(posedge clk); #1; wr_cmd_full = 1'b0;
    repeat (10) @(negedge clk);
    chk("R5 push after release", {rc_n[7:0], wc_n[7:0]}, {8'd1, 8'd1});
    chk("R8 walk ended, reads so far", r_n, 5);
    kick(40);
    repeat (10) @(negedge clk);
    chk("R8 start ignored while busy", r_n, 5);
    send_rd(24'h000123);
    send_wr(24'h000456);
    wait_idle();
    chk("R8 no extra read", r_n, 5);
    chk("R6 stalled case rd word", mem[12], 32'h8000_0123);

    // R9 pending limit and R7 ordering across a chain of six
    clear_logs();
    for (int k = 0; k < 6; k++) begin
      vec_t v;
      v.src = 16'h0100 + 16'(k); v.dst = 16'h0200 + 16'(k);
      v.len = 16'(k + 1); v.flg = 3'(k); v.rtok = '0; v.wtok = '0;
      put_desc(8*(k+1), v, 8*(k+2));
    end
    mem[58] = '0;
    kick(8);
    repeat (60) @(negedge clk);
    chk("R9 pushes capped at depth", rc_n, 4);
    chk("R9 busy while capped", busy, 1);
    for (int k = 0; k < 6; k++) begin
      send_rd(24'h000100 + 24'(k));
      send_wr(24'h010200 + 24'(k));
    end
    wait_idle();
    chk("R9 all commands issued", rc_n, 6);
    for (int k = 0; k < 6; k++) begin
      vec_t v;
      v.src = 16'h0100 + 16'(k); v.dst = 16'h0200 + 16'(k);
      v.len = 16'(k + 1); v.flg = 3'(k); v.rtok = '0; v.wtok = '0;
      chk($sformatf("R3 chain cmd %0d", k), rcmd[k], exp_cmd(v));
      chk($sformatf("R7 write order %0d", k), {wblog[2*k], wblog[2*k+1]},
          {16'(8*(k+1)+4), 16'(8*(k+1)+5)});
      chk($sformatf("R6 chain words %0d", k), {mem[8*(k+1)+4], mem[8*(k+1)+5]},
          {32'h8000_0100 + 32'(k), 32'h8001_0200 + 32'(k)});
    end
    chk("R7 write count", wb_n, 12);

    finish_run();
  end
endmodule